// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host reach the management registers of Ethernet PHY devices over a two-wire MDIO link. The host sees three 16-bit registers on a small register bus. It stages the value to send in the write-data register. A single write to the command register, carrying an operation code, a PHY address and a register number, then starts a complete Clause 22 frame. While the frame runs, an idle flag in the command register reads 0. The host polls that flag. After a read frame it collects the 16-bit result from the read-data register.

Inside, a free-running divider makes MDC from the system clock and gives one-cycle strobes for the rising and falling edges of MDC. A sequencer walks a frame through six named states:
- `ST_IDLE` goes to `ST_PREAMBLE` on an accepted command.
- `ST_PREAMBLE` goes to `ST_HEADER` after the last preamble bit.
- `ST_HEADER` goes to `ST_TURN` after the 14th header bit.
- `ST_TURN` goes to `ST_DATA` after the second turnaround bit.
- `ST_DATA` goes to `ST_FINISH` after the 16th data bit.
- `ST_FINISH` goes back to `ST_IDLE` on the next MDC falling edge.

Every move between states other than the first happens only on an MDC falling edge. The line is driven and released only on those same edges. Read data is sampled on MDC rising edges.

Top module: `mdio_host_master`

## Requirements
- R1: Register map at byte offsets 0x0, 0x2 and 0x4. Offset 0x0 is the command register: bits [4:0] register number, [9:5] PHY address, [11:10] operation, bit 12 idle flag. Reading it returns the last accepted command in bits [11:0], the idle flag in bit 12 and zero in bits [15:13]. Offset 0x2 is the write-data register, which reads back what was last written. Offset 0x4 is the read-data register. Any other offset reads zero.
- R2: After reset the idle flag is 1, `mdio_oe` is 0, MDC is low, and the read-data and command registers hold zero.
- R3: MDC has a period of 2*MDC_HALF system clocks. `mdio_o` changes only in the cycle in which MDC falls.
- R4: Every frame drives 32 ones, then start bits 0 then 1, then the 2-bit operation, the 5-bit PHY address and the 5-bit register number, each MSB first, with `mdio_oe` high.
- R5: For operation 1 (write) the master drives turnaround bits 1 then 0, then the 16 staged data bits MSB first, keeping `mdio_oe` high for all 64 bits.
- R6: For operation 2 (read) `mdio_oe` is low during the two turnaround bits and the 16 data bits. The 16 bits of `mdio_i` sampled on the MDC rising edges, MSB first, are placed in the read-data register when the frame ends. The read-data register changes at no other time.
- R7: The idle flag reads 0 from the cycle after the accepted command write, through the 64th MDC rising edge of the frame, and returns to 1 at the following MDC falling edge.
- R8: A command write while the idle flag is 0 is ignored: the frame in flight, the command readback and the following idle period are unaffected.
- R9: A command write with operation 0 or 3 starts no frame, keeps the idle flag at 1 and `mdio_oe` at 0, and leaves the command readback unchanged.
- R10: The write data is taken when the command is accepted. A later write to the write-data register during the frame does not change the bits on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The hardest situation to reach from the ports is a command or data-register write that arrives in the middle of a frame. It must leave no trace on the line or in the registers. The bench reaches it by starting a write frame and waiting a fixed number of cycles, so that the frame is inside its preamble. It then writes a different command and a different data word. After that it compares the recorded frame bit by bit against the first command, checks the readbacks, and watches that no second frame follows. A behavioural PHY in the bench answers read frames on MDC falling edges, so that rising-edge sampling and the exact end of the busy window can be checked.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } seq_state_t;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [2:0] OFS_CMD   = 3'h0;
    localparam logic [2:0] OFS_WDATA = 3'h2;
    localparam logic [2:0] OFS_RDATA = 3'h4;

    localparam int CMD_W  = 12;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 14;
    localparam int TA_W   = 2;

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] regn;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

    logic [CW-1:0] div_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap      = (div_q == LAST);
    assign rise_tick = wrap & ~mdc_q;
    assign fall_tick = wrap & mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick, fall_tick}));

    p_mdc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick || fall_tick) |=> $stable(mdc));

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  idle,
    input  logic                  rd_done,
    input  logic [DATA_W-1:0]     rd_value,
    output logic                  cmd_start,
    output mdio_cmd_t             cmd,
    output logic [DATA_W-1:0]     wdata
);
    mdio_cmd_t         cmd_q;
    mdio_cmd_t         cmd_in;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              op_valid;

    assign cmd_in    = mdio_cmd_t'(bus_wdata[CMD_W-1:0]);
    assign op_valid  = (cmd_in.op == OP_READ) || (cmd_in.op == OP_WRITE);
    assign cmd_start = bus_wr && (bus_addr == OFS_CMD) && idle && op_valid;
    assign cmd       = cmd_in;
    assign wdata     = wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (cmd_start) begin
                cmd_q <= cmd_in;
            end
            if (bus_wr && (bus_addr == OFS_WDATA)) begin
                wdata_q <= bus_wdata;
            end
            if (rd_done) begin
                rdata_q <= rd_value;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CMD:   bus_rdata = {3'b000, idle, cmd_q};
            OFS_WDATA: bus_rdata = wdata_q;
            OFS_RDATA: bus_rdata = rdata_q;
            default:   bus_rdata = '0;
        endcase
    end

    p_rdata_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(rdata_q));

    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cmd_q));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              idle,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] TA_LAST   = CNT_W'(TA_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              is_read_q;
    logic              samp_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PREAMBLE;
                    cnt_d   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (fall_tick) begin
                    if (cnt_q == PRE_LAST) begin
                        state_d = ST_HEADER;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HEADER: begin
                if (fall_tick) begin
                    if (cnt_q == HDR_LAST) begin
                        state_d = ST_TURN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (fall_tick) begin
                    if (cnt_q == TA_LAST) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (fall_tick) begin
                    if (cnt_q == DATA_LAST) begin
                        state_d = ST_FINISH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                if (fall_tick) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            hdr_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            is_read_q <= 1'b0;
            samp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start) begin
                hdr_q     <= {2'b01, cmd.op, cmd.phy, cmd.regn};
                tx_q      <= wdata;
                is_read_q <= (cmd.op == OP_READ);
            end
            if (fall_tick) begin
                samp_q <= (state_q == ST_DATA) && is_read_q;
                if (state_q == ST_HEADER) begin
                    hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                end
                if (state_q == ST_DATA) begin
                    tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
            if (rise_tick && samp_q) begin
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // line outputs, updated only on MDC falling edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (fall_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    mdio_o  <= mdio_o;
                    mdio_oe <= mdio_oe;
                end
                ST_PREAMBLE: begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
                ST_HEADER: begin
                    mdio_o  <= hdr_q[HDR_W-1];
                    mdio_oe <= 1'b1;
                end
                ST_TURN: begin
                    mdio_o  <= is_read_q ? 1'b1 : (cnt_q == '0);
                    mdio_oe <= !is_read_q;
                end
                ST_DATA: begin
                    mdio_o  <= is_read_q ? 1'b1 : tx_q[DATA_W-1];
                    mdio_oe <= !is_read_q;
                end
                ST_FINISH: begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end
                default: begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end
            endcase
        end
    end

    assign idle     = (state_q == ST_IDLE);
    assign rd_done  = fall_tick && (state_q == ST_FINISH) && is_read_q;
    assign rd_value = rx_q;

    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdio_oe);

    p_line_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(mdio_o));

    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) && is_read_q |-> !mdio_oe);

    p_kind_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(is_read_q));

    p_leave_idle_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !start |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              rise_tick;
    logic              fall_tick;
    logic              idle;
    logic              rd_done;
    logic [DATA_W-1:0] rd_value;
    logic              cmd_start;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] wdata;

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .idle      (idle),
        .rd_done   (rd_done),
        .rd_value  (rd_value),
        .cmd_start (cmd_start),
        .cmd       (cmd),
        .wdata     (wdata)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .cmd       (cmd),
        .wdata     (wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .idle      (idle),
        .rd_done   (rd_done),
        .rd_value  (rd_value)
    );

endmodule

// File: tb/test_mdio_host_master.sv
`timescale 1ns/1ps
module test_mdio_host_master;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #2.5 clk = ~clk;

    mdio_host_master #(.MDC_HALF(HALF), .PRE_LEN(32)) i_mdio_host_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // vector: op[43:42] phy[41:37] reg[36:32] wdata[31:16] phy_reply[15:0]
    localparam int NVEC = 6;
    localparam logic [43:0] VEC [0:NVEC-1] = '{
        {2'b01, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
        {2'b10, 5'h1F, 5'h1F, 16'h0000, 16'hBEEF},
        {2'b01, 5'h10, 5'h0A, 16'hFFFF, 16'h0000},
        {2'b10, 5'h00, 5'h01, 16'h0000, 16'h8001},
        {2'b01, 5'h0B, 5'h15, 16'h0001, 16'h0000},
        {2'b10, 5'h15, 5'h0B, 16'h0000, 16'h5AA5}
    };

    // bench line monitor and behavioural PHY
    logic [1:0]  cur_op = 2'b00;
    logic [15:0] cur_reply = 16'h0;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b1;
    logic        active = 1'b0;
    int          nbits = 0;
    logic [63:0] rec_line = '0;
    logic [63:0] rec_oe = '0;
    logic        idle_at_last = 1'b1;
    int          glitches = 0;
    int          oe_seen = 0;
    int          clk_since_rise = 0;
    int          last_period = 0;

    assign mdio_i = phy_en ? phy_val : 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            clk_since_rise = clk_since_rise + 1;
            if (mdio_oe) oe_seen = oe_seen + 1;
            if (mdio_o !== prev_o && !(prev_mdc && !mdc)) glitches = glitches + 1;
            if (!active && mdio_oe) begin
                active = 1'b1;
                nbits  = 0;
                rec_line = '0;
                rec_oe   = '0;
            end
            if (prev_mdc && !mdc) begin
                if (active && cur_op == 2'b10 && nbits >= 47 && nbits <= 63) begin
                    phy_en  = 1'b1;
                    phy_val = (nbits == 47) ? 1'b0 : cur_reply[63 - nbits];
                end else begin
                    phy_en = 1'b0;
                end
            end
            if (!prev_mdc && mdc) begin
                last_period    = clk_since_rise;
                clk_since_rise = 0;
                if (active && nbits < 64) begin
                    rec_line[63 - nbits] = mdio_oe ? mdio_o : mdio_i;
                    rec_oe[63 - nbits]   = mdio_oe;
                    nbits = nbits + 1;
                    if (nbits == 64) idle_at_last = bus_rdata_idle();
                end
            end
            prev_mdc = mdc;
            prev_o   = mdio_o;
        end
    end

    function automatic logic bus_rdata_idle();
        return i_mdio_host_master.bus_rdata[12] & (bus_addr == 3'h0) | (bus_addr != 3'h0) & idle_probe;
    endfunction

    logic idle_probe = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 3'h0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 3'h0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int guard;
        guard = 0;
        v = 16'h0;
        while (v[12] == 1'b0 && guard < 4000) begin
            bus_read(3'h0, v);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
        active = 1'b0;
    endtask

    task automatic check_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] wd, input string tag);
        logic [45:0] hdr;
        hdr = {32'hFFFF_FFFF, 2'b01, op, phy, rg};
        chk(nbits == 64, {"R7 bit count ", tag}, 64'(nbits), 64);
        chk(rec_line[63:18] == hdr, {"R4 header ", tag}, 64'(rec_line[63:18]), 64'(hdr));
        if (op == 2'b01) begin
            chk(rec_line[17:0] == {2'b10, wd}, {"R5 turnaround+data ", tag},
                64'(rec_line[17:0]), 64'({2'b10, wd}));
            chk(rec_oe == '1, {"R5 oe pattern ", tag}, rec_oe, '1);
        end else begin
            chk(rec_oe == {{46{1'b1}}, 18'h0}, {"R6 oe pattern ", tag}, rec_oe, {{46{1'b1}}, 18'h0});
        end
        chk(idle_at_last == 1'b0, {"R7 busy at last rise ", tag}, 64'(idle_at_last), 0);
    endtask

    task automatic start_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] reply);
        logic [15:0] v;
        cur_op    = op;
        cur_reply = reply;
        bus_write(3'h2, wd);
        bus_write(3'h0, {4'h0, op, phy, rg});
        v = bus_rdata;
        chk(v[12] == 1'b0, "R7 idle low after launch", 64'(v), 0);
    endtask

    initial begin
        logic [15:0] v;
        int g0;
        idle_probe = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        chk(mdio_oe == 1'b0, "R2 oe after reset", 64'(mdio_oe), 0);
        chk(mdc == 1'b0, "R2 mdc after reset", 64'(mdc), 0);
        bus_read(3'h0, v);
        chk(v == 16'h1000, "R2 command reg after reset", 64'(v), 64'h1000);
        bus_read(3'h4, v);
        chk(v == 16'h0000, "R2 read data after reset", 64'(v), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(last_period == 2 * HALF, "R3 mdc period", 64'(last_period), 64'(2 * HALF));

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] e;
            e = VEC[i];
            start_cmd(e[43:42], e[41:37], e[36:32], e[31:16], e[15:0]);
            wait_idle();
            check_frame(e[43:42], e[41:37], e[36:32], e[31:16], $sformatf("vec%0d", i));
            bus_read(3'h0, v);
            chk(v == {4'h1, e[43:32]}, "R1 command readback", 64'(v), 64'({4'h1, e[43:32]}));
            if (e[43:42] == 2'b10) begin
                bus_read(3'h4, v);
                chk(v == e[15:0], "R6 read data", 64'(v), 64'(e[15:0]));
            end
        end
        chk(glitches == 0, "R3 mdio_o moved off a falling edge", 64'(glitches), 0);

        // mid-frame command and data writes
        start_cmd(2'b01, 5'h03, 5'h04, 16'h1234, 16'h0);
        repeat (40) @(negedge clk);
        bus_write(3'h0, {4'h0, 2'b10, 5'h1E, 5'h1D});
        bus_write(3'h2, 16'hCAFE);
        wait_idle();
        check_frame(2'b01, 5'h03, 5'h04, 16'h1234, "busy write");
        bus_read(3'h0, v);
        chk(v == {4'h1, 2'b01, 5'h03, 5'h04}, "R8 readback after busy write", 64'(v),
            64'({4'h1, 2'b01, 5'h03, 5'h04}));
        bus_read(3'h2, v);
        chk(v == 16'hCAFE, "R10 R1 write-data readback", 64'(v), 64'hCAFE);
        bus_read(3'h4, v);
        chk(v == 16'h5AA5, "R6 read data untouched by write frame", 64'(v), 64'h5AA5);
        oe_seen = 0;
        repeat (60) @(negedge clk);
        chk(oe_seen == 0, "R8 no second frame", 64'(oe_seen), 0);

        // no-operation codes
        for (int k = 0; k < 2; k++) begin
            logic [1:0] nop;
            nop = (k == 0) ? 2'b00 : 2'b11;
            oe_seen = 0;
            bus_write(3'h0, {4'h0, nop, 5'h07, 5'h08});
            bus_read(3'h0, v);
            chk(v == {4'h1, 2'b01, 5'h03, 5'h04}, "R9 nop leaves idle and readback", 64'(v),
                64'({4'h1, 2'b01, 5'h03, 5'h04}));
            repeat (40) @(negedge clk);
            chk(oe_seen == 0, "R9 nop drives nothing", 64'(oe_seen), 0);
        end

        bus_read(3'h6, v);
        chk(v == 16'h0, "R1 unmapped offset", 64'(v), 0);
        g0 = glitches;
        chk(g0 == 0, "R3 line stable between falling edges", 64'(g0), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule